// File: doc/BRIEF.md
# Flash Status Register With Snapshot Read Path

This block holds the 8-bit status word of a parallel NOR-style flash device and returns it on the 16-bit data bus. An internal write/erase engine drives level inputs for readiness and the two suspend flags. It also sends one-cycle set pulses for the four error flags and for a command sequence error. A command decoder sends strobes that select status output, leave it, and clear the error flags.

The host-side active-low chip-enable and output-enable pins each pass through two synchronizing flops. A three-state latch machine then watches them. States: `LS_DESEL` (chip not enabled), `LS_ARMED` (chip enabled, output enable high) and `LS_SHOW` (both enabled, snapshot held). The status word is copied into a snapshot register on the transition into `LS_SHOW`. Transitions:
- `LS_DESEL`→`LS_SHOW`: both pins become active together, so the chip-enable edge captures.
- `LS_DESEL`→`LS_ARMED`: chip enable only.
- `LS_ARMED`→`LS_SHOW`: the output-enable falling edge captures.
- `LS_ARMED`→`LS_DESEL`: deselect.
- `LS_SHOW`→`LS_ARMED`: output enable returns high.
- `LS_SHOW`→`LS_DESEL`: deselect.

While the machine stays in `LS_SHOW`, the bus keeps showing the same, possibly stale, snapshot. A second two-state machine, `MD_ARRAY`↔`MD_STATUS`, records whether status output is selected. The read-status strobe takes it to `MD_STATUS`. The exit strobe takes it back to `MD_ARRAY` unless a read-status strobe arrives in the same cycle.

Top module: `flash_stat_reg`

## Requirements
- R1: After reset the status word is 0x80 and `dq_oe` is 0. The first status read after reset returns 0x0080.
- R2: Bit 7 follows `eng_ready`, bit 6 follows `eng_ers_susp` and bit 2 follows `eng_prg_susp`, each one clock later. Bit 0 always reads 0.
- R3: A pulse on `set_ers_err`, `set_prg_err`, `set_vpp_err` or `set_lock_err` sets bit 5, 4, 3 or 1 respectively. The bit stays set after the pulse ends.
- R4: `cmd_clr_stat` clears bits 5, 4, 3 and 1 and leaves bits 7, 6, 2 and 0 unchanged.
- R5: If a set pulse and `cmd_clr_stat` arrive in the same cycle, the set bit ends up 1.
- R6: A pulse on `set_seq_err` sets bits 5 and 4 together.
- R7: `dq_oe` is 1 only in `MD_STATUS` with the latch in `LS_SHOW`. Then `dq[7:0]` is the snapshot and `dq[15:8]` is 0x00. When `dq_oe` is 0, `dq` is 0.
- R8: While both pins stay active, `dq` does not change, even when the status word does.
- R9: Raising `oe_n`, or raising `ce_n`, and then re-enabling takes a fresh snapshot.
- R10: While bit 7 is 0, bits 6:1 are returned unmasked.
- R11: `cmd_exit_stat` returns to `MD_ARRAY`, and `dq_oe` drops to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_ready | input | 1 | Engine idle level (1 = ready) |
| eng_ers_susp | input | 1 | Erase suspended level |
| eng_prg_susp | input | 1 | Program suspended level |
| set_ers_err | input | 1 | Erase error set pulse |
| set_prg_err | input | 1 | Program error set pulse |
| set_vpp_err | input | 1 | Program/erase voltage error set pulse |
| set_lock_err | input | 1 | Locked-block abort set pulse |
| set_seq_err | input | 1 | Command sequence error set pulse |
| cmd_rd_stat | input | 1 | Select status output strobe |
| cmd_clr_stat | input | 1 | Clear error flags strobe |
| cmd_exit_stat | input | 1 | Leave status output strobe |
| ce_n | input | 1 | Asynchronous chip enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | output | 16 | Data bus value |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The checker asserts on every cycle:
- the upper byte of the bus is always zero, and the bus is quiet when not driven;
- the bus value is stable for as long as it stays driven;
- error flags stick until a clear, each set pulse lands one cycle later, and a clear empties them;
- readiness is mirrored with one cycle of delay.

Only the bench scenarios can show some things:
- snapshot staleness against a changing word, and the refresh after output-enable or chip-enable cycling;
- that set wins over a simultaneous clear;
- the unmasked busy value;
- the exit from status mode.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int SR_W   = 8;
    localparam int DQ_W   = 16;
    localparam int B_RDY  = 7;
    localparam int B_ESUS = 6;
    localparam int B_ERS  = 5;
    localparam int B_PRG  = 4;
    localparam int B_VPP  = 3;
    localparam int B_PSUS = 2;
    localparam int B_LOCK = 1;
    localparam logic [SR_W-1:0] SR_RST = 8'h80;

    typedef enum logic [1:0] {LS_DESEL, LS_ARMED, LS_SHOW} lat_st_t;
    typedef enum logic {MD_ARRAY, MD_STATUS} mode_t;
endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
    parameter int W = 2,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= {STAGES{RST_VAL}};
                else        stg[0] <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= {STAGES{RST_VAL}};
                else        stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fsr_core.sv
module fsr_core
    import fsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            eng_ready,
    input  logic            eng_ers_susp,
    input  logic            eng_prg_susp,
    input  logic            set_ers,
    input  logic            set_prg,
    input  logic            set_vpp,
    input  logic            set_lock,
    input  logic            set_seq,
    input  logic            clr,
    input  logic            rd_stat,
    input  logic            exit_stat,
    output logic [SR_W-1:0] sr,
    output logic            stat_sel
);
    logic [SR_W-1:0] sr_q, sr_d;
    mode_t md_q, md_d;

    always_comb begin
        sr_d         = sr_q;
        sr_d[B_RDY]  = eng_ready;
        sr_d[B_ESUS] = eng_ers_susp;
        sr_d[B_PSUS] = eng_prg_susp;
        sr_d[0]      = 1'b0;
        sr_d[B_ERS]  = (sr_q[B_ERS]  & ~clr) | set_ers | set_seq;
        sr_d[B_PRG]  = (sr_q[B_PRG]  & ~clr) | set_prg | set_seq;
        sr_d[B_VPP]  = (sr_q[B_VPP]  & ~clr) | set_vpp;
        sr_d[B_LOCK] = (sr_q[B_LOCK] & ~clr) | set_lock;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= SR_RST;
        else        sr_q <= sr_d;
    end

    always_comb begin
        md_d = md_q;
        unique case (md_q)
            MD_ARRAY:  if (rd_stat) md_d = MD_STATUS;
            MD_STATUS: if (exit_stat && !rd_stat) md_d = MD_ARRAY;
            default:   md_d = MD_ARRAY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) md_q <= MD_ARRAY;
        else        md_q <= md_d;
    end

    assign sr       = sr_q;
    assign stat_sel = (md_q == MD_STATUS);
endmodule

// File: rtl/fsr_latch.sv
module fsr_latch
    import fsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce_act,
    input  logic            oe_act,
    input  logic [SR_W-1:0] sr,
    output logic [SR_W-1:0] snap,
    output logic            show
);
    lat_st_t st_q, st_d;
    logic    capture;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LS_DESEL: begin
                if (ce_act && oe_act) st_d = LS_SHOW;
                else if (ce_act)      st_d = LS_ARMED;
            end
            LS_ARMED: begin
                if (!ce_act)     st_d = LS_DESEL;
                else if (oe_act) st_d = LS_SHOW;
            end
            LS_SHOW: begin
                if (!ce_act)      st_d = LS_DESEL;
                else if (!oe_act) st_d = LS_ARMED;
            end
            default: st_d = LS_DESEL;
        endcase
    end

    assign capture = (st_d == LS_SHOW) && (st_q != LS_SHOW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LS_DESEL;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap <= SR_RST;
        else if (capture) snap <= sr;
    end

    assign show = (st_q == LS_SHOW);
endmodule

// File: rtl/flash_stat_reg.sv
module flash_stat_reg
    import fsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            eng_ready,
    input  logic            eng_ers_susp,
    input  logic            eng_prg_susp,
    input  logic            set_ers_err,
    input  logic            set_prg_err,
    input  logic            set_vpp_err,
    input  logic            set_lock_err,
    input  logic            set_seq_err,
    input  logic            cmd_rd_stat,
    input  logic            cmd_clr_stat,
    input  logic            cmd_exit_stat,
    input  logic            ce_n,
    input  logic            oe_n,
    output logic [DQ_W-1:0] dq,
    output logic            dq_oe
);
    localparam int PAD_W = DQ_W - SR_W;

    logic [1:0]      pins_s;
    logic [SR_W-1:0] sr_q;
    logic [SR_W-1:0] snap;
    logic            show;
    logic            stat_sel;

    fsr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d ({ce_n, oe_n}),
        .q (pins_s)
    );

    fsr_core u_core (
        .clk (clk),
        .rst_n (rst_n),
        .eng_ready (eng_ready),
        .eng_ers_susp (eng_ers_susp),
        .eng_prg_susp (eng_prg_susp),
        .set_ers (set_ers_err),
        .set_prg (set_prg_err),
        .set_vpp (set_vpp_err),
        .set_lock (set_lock_err),
        .set_seq (set_seq_err),
        .clr (cmd_clr_stat),
        .rd_stat (cmd_rd_stat),
        .exit_stat (cmd_exit_stat),
        .sr (sr_q),
        .stat_sel (stat_sel)
    );

    fsr_latch u_latch (
        .clk (clk),
        .rst_n (rst_n),
        .ce_act (~pins_s[1]),
        .oe_act (~pins_s[0]),
        .sr (sr_q),
        .snap (snap),
        .show (show)
    );

    assign dq_oe = show & stat_sel;
    assign dq    = dq_oe ? {{PAD_W{1'b0}}, snap} : '0;
endmodule

// File: rtl/fsr_chk.sv
module fsr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  sr,
    input logic [15:0] dq,
    input logic        dq_oe,
    input logic        eng_ready,
    input logic        set_ers_err,
    input logic        set_prg_err,
    input logic        set_seq_err,
    input logic        cmd_clr_stat
);
    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dq[15:8] == 8'h00);

    p_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq == 16'h0000));

    p_bit0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dq[0] == 1'b0);

    p_rdy_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_ready |=> sr[7]);

    p_busy_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_ready |=> !sr[7]);

    p_prg_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_prg_err |=> sr[4]);

    p_ers_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sr[5] && !cmd_clr_stat) |=> sr[5]);

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clr_stat && !set_ers_err && !set_seq_err) |=> !sr[5]);

    p_seq_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_seq_err |=> (sr[5] && sr[4]));

    p_stale_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(dq_oe)) |-> $stable(dq));
endmodule

bind flash_stat_reg fsr_chk chk_i (
    .clk (clk),
    .rst_n (rst_n),
    .sr (sr_q),
    .dq (dq),
    .dq_oe (dq_oe),
    .eng_ready (eng_ready),
    .set_ers_err (set_ers_err),
    .set_prg_err (set_prg_err),
    .set_seq_err (set_seq_err),
    .cmd_clr_stat (cmd_clr_stat)
);

// File: tb/flash_stat_reg_tb_top.sv
`timescale 1ns/1ps
module flash_stat_reg_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eng_ready = 1'b1, eng_ers_susp = 1'b0, eng_prg_susp = 1'b0;
    logic set_ers_err = 1'b0, set_prg_err = 1'b0, set_vpp_err = 1'b0;
    logic set_lock_err = 1'b0, set_seq_err = 1'b0;
    logic cmd_rd_stat = 1'b0, cmd_clr_stat = 1'b0, cmd_exit_stat = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1;
    logic [15:0] dq;
    logic dq_oe;
    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    flash_stat_reg dut_i (
        .clk (clk), .rst_n (rst_n),
        .eng_ready (eng_ready), .eng_ers_susp (eng_ers_susp), .eng_prg_susp (eng_prg_susp),
        .set_ers_err (set_ers_err), .set_prg_err (set_prg_err), .set_vpp_err (set_vpp_err),
        .set_lock_err (set_lock_err), .set_seq_err (set_seq_err),
        .cmd_rd_stat (cmd_rd_stat), .cmd_clr_stat (cmd_clr_stat), .cmd_exit_stat (cmd_exit_stat),
        .ce_n (ce_n), .oe_n (oe_n), .dq (dq), .dq_oe (dq_oe)
    );

    // vector: [16]seq [15]lock [14]vpp [13]prg [12]ers [11]clr [10]rdy [9]esus [8]psus [7:0]expected
    localparam logic [16:0] VEC [8] = '{
        {5'b00000, 1'b0, 3'b100, 8'h80},   // R1 initial word
        {5'b00010, 1'b0, 3'b100, 8'h90},   // R3 program error
        {5'b00110, 1'b0, 3'b100, 8'h98},   // R3 voltage + program
        {5'b00000, 1'b1, 3'b100, 8'h80},   // R4 clear
        {5'b01001, 1'b0, 3'b100, 8'hA2},   // R3 locked + erase
        {5'b00010, 1'b1, 3'b100, 8'h90},   // R5 set beats clear
        {5'b10000, 1'b0, 3'b100, 8'hB0},   // R6 sequence error
        {5'b00000, 1'b1, 3'b011, 8'h44}    // R10 R2 busy, suspends unmasked
    };

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_cmd(input int which);
        @(negedge clk);
        case (which)
            0: cmd_rd_stat = 1'b1;
            1: cmd_clr_stat = 1'b1;
            default: cmd_exit_stat = 1'b1;
        endcase
        @(negedge clk);
        cmd_rd_stat = 1'b0; cmd_clr_stat = 1'b0; cmd_exit_stat = 1'b0;
    endtask

    task automatic reread();
        oe_n = 1'b1;
        ticks(4);
        oe_n = 1'b0;
        ticks(4);
    endtask

    initial begin
        ticks(3);
        check("R1 dq_oe in reset", {dq_oe, dq}, 17'h0);
        rst_n = 1'b1;
        ticks(2);
        ce_n = 1'b0; oe_n = 1'b0;
        ticks(5);
        check("R7 no drive outside status mode", {dq_oe, dq}, 17'h0);
        pulse_cmd(0);
        ticks(1);

        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            {set_seq_err, set_lock_err, set_vpp_err, set_prg_err, set_ers_err} = VEC[i][16:12];
            cmd_clr_stat = VEC[i][11];
            {eng_ready, eng_ers_susp, eng_prg_susp} = VEC[i][10:8];
            @(negedge clk);
            {set_seq_err, set_lock_err, set_vpp_err, set_prg_err, set_ers_err} = 5'b0;
            cmd_clr_stat = 1'b0;
            reread();
            check($sformatf("R3 R4 R5 R6 R10 R2 vector %0d", i), {dq_oe, dq}, {1'b1, 8'h00, VEC[i][7:0]});
        end

        // restore ready, clear errors
        eng_ready = 1'b1; eng_ers_susp = 1'b0; eng_prg_susp = 1'b0;
        pulse_cmd(1);
        reread();
        check("R4 clear leaves ready only", {dq_oe, dq}, 17'h1_0080);

        // stale snapshot while held
        @(negedge clk); set_vpp_err = 1'b1;
        @(negedge clk); set_vpp_err = 1'b0;
        ticks(6);
        check("R8 snapshot stale while held", {dq_oe, dq}, 17'h1_0080);
        reread();
        check("R9 refresh after oe cycle", {dq_oe, dq}, 17'h1_0088);

        // refresh through deselect with oe held low
        @(negedge clk); set_lock_err = 1'b1;
        @(negedge clk); set_lock_err = 1'b0;
        ticks(4);
        check("R8 stale before deselect", {dq_oe, dq}, 17'h1_0088);
        ce_n = 1'b1;
        ticks(4);
        check("R7 deselected no drive", {dq_oe, dq}, 17'h0);
        ce_n = 1'b0;
        ticks(4);
        check("R9 refresh after ce cycle", {dq_oe, dq}, 17'h1_008A);

        // exit status mode
        pulse_cmd(2);
        ticks(1);
        check("R11 exit drops drive", {dq_oe, dq}, 17'h0);

        // reset mid-run returns default
        rst_n = 1'b0;
        ticks(2);
        rst_n = 1'b1;
        pulse_cmd(0);
        reread();
        check("R1 default after reset", {dq_oe, dq}, 17'h1_0080);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule